// File: doc/BRIEF.md
# Legacy Memory Region Decoder

This block classifies every memory access that falls in the upper part of the first megabyte, from 0xA0000 to 0xFFFFF. For each one it decides whether the access is served by system DRAM or passed on to the expansion (ISA) bus. It also decides whether a write has to be suppressed because the target is shadowed read-only. Addresses outside that range are treated as ordinary DRAM traffic.

The decision depends on three things. The first is a set of attribute fields, each 2 bits wide, that are packed two to a byte into configuration bytes 0x59 to 0x5F. The second is a system-management RAM control byte at offset 0x72, which opens the 0xA0000 to 0xBFFFF video window. The third is an input that reports whether the processor is in system-management mode. Software loads these settings through a byte-wide write port. The decoder returns a DRAM-select flag and a write-block flag for each access, one clock after the access is presented.

Top module: `legacy_region_decoder`

## Requirements
- R1: Reset is synchronous and active-high. After reset all attribute fields read as 0, and the control byte at 0x72 holds 0x02, which leaves bits 6 and 3 clear. During reset, and for every access in 0xA0000 to 0xFFFFF after reset, both `dram_sel` and `wr_block` are 0.
- R2: `dram_sel` and `wr_block` are registered. They reflect the access presented on `acc_addr`, `acc_write` and `smm_active` in the cycle before, evaluated against the configuration that held in that cycle.
- R3: Addresses 0xF0000 to 0xFFFFF take their attribute from bits 5:4 of byte 0x59.
- R4: Addresses 0xC0000 to 0xEFFFF form twelve 16 KB segments. Segment k = (addr − 0xC0000) >> 14 takes its attribute from byte 0x5A + (k >> 1), using bits 1:0 when k is even and bits 5:4 when k is odd.
- R5: Attribute 3 gives `dram_sel`=1 and `wr_block`=0 for both reads and writes.
- R6: Attribute 1 gives `dram_sel`=1. `wr_block` is then 1 for a write (`acc_write`=1) and 0 for a read. A read never sets `wr_block`.
- R7: Attributes 0 and 2 give `dram_sel`=0 and `wr_block`=0, so the access goes to the ISA bus.
- R8: Addresses 0xA0000 to 0xBFFFF give `dram_sel`=1 when bit 6 of byte 0x72 is set, or when `smm_active`=1 and bit 3 of byte 0x72 is set. In all other cases they give `dram_sel`=0. `wr_block` is always 0 in this window.
- R9: `smm_active` has no effect on the outputs while bit 3 of 0x72 is clear. It also has no effect for any address outside 0xA0000 to 0xBFFFF.
- R10: Any address below 0xA0000 or above 0xFFFFF gives `dram_sel`=1 and `wr_block`=0, whatever the configuration.
- R11: A configuration write, issued with `cfg_we`=1, changes the decoding only for accesses presented in later cycles; an access in the same cycle still sees the old setting. Writes to offsets other than 0x59 to 0x5F and 0x72 are ignored, and so are the bits of those bytes that carry no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| smm_active | input | 1 | Processor is in system-management mode |
| acc_addr | input | ADDR_W | Physical address of the current access |
| acc_write | input | 1 | Current access is a write |
| dram_sel | output | 1 | Access is served by DRAM (0: forward to ISA bus) |
| wr_block | output | 1 | Write must not reach DRAM |

## Verification
Both flags appear one clock after their access is presented. A configuration write becomes visible in the outputs two clocks after it is issued: it is stored at the first edge, and an access presented after that edge is registered at the second edge. The bench drives everything at the falling edge. At that same falling edge it computes the expected flags from its own copy of the configuration bytes, taken before that cycle's write is applied, and compares them with the outputs at the next falling edge. This keeps both delays and the rule that a same-cycle write is not yet seen.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  typedef enum logic [1:0] {
    AT_FWD_A  = 2'd0,
    AT_RDONLY = 2'd1,
    AT_FWD_B  = 2'd2,
    AT_RDWR   = 2'd3
  } attr_e;

  typedef enum logic [1:0] {
    RG_OUTSIDE = 2'd0,
    RG_VIDEO   = 2'd1,
    RG_SEG     = 2'd2,
    RG_TOP     = 2'd3
  } region_e;

  localparam logic [7:0] ATTR_BASE_OFF  = 8'h59;
  localparam logic [7:0] SMRAM_OFF      = 8'h72;
  localparam logic [7:0] SMRAM_RESET    = 8'h02;
  localparam int         SMRAM_OPEN_BIT = 6;
  localparam int         SMRAM_SMM_BIT  = 3;
  localparam int         HI_FIELD_LSB   = 4;
  localparam int         SEG_SHIFT      = 14;

endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs
  import lrd_pkg::*;
#(
  parameter int NUM_SEG = 12,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [OFF_W-1:0]     cfg_off,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [1:0]           top_attr,
  output logic [NUM_SEG*2-1:0] seg_attr_flat,
  output logic                 smram_open,
  output logic                 smram_smm_en
);

  logic cfg_bits_unused;
  assign cfg_bits_unused = ^{cfg_wdata[7], cfg_wdata[2]};

  // top 64 KB field: byte 0x59, bits 5:4
  always_ff @(posedge clk) begin
    if (rst)
      top_attr <= 2'b00;
    else if (cfg_we && cfg_off == ATTR_BASE_OFF)
      top_attr <= cfg_wdata[HI_FIELD_LSB +: 2];
  end

  // one 2-bit field per 16 KB segment, two segments per byte
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [OFF_W-1:0] SEG_OFF = ATTR_BASE_OFF + OFF_W'(1 + (s >> 1));
    localparam int               SEG_LSB = (s & 1) * HI_FIELD_LSB;
    always_ff @(posedge clk) begin
      if (rst)
        seg_attr_flat[s*2 +: 2] <= 2'b00;
      else if (cfg_we && cfg_off == SEG_OFF)
        seg_attr_flat[s*2 +: 2] <= cfg_wdata[SEG_LSB +: 2];
    end
  end

  // SMRAM control: only the two bits the decoder uses are kept
  always_ff @(posedge clk) begin
    if (rst) begin
      smram_open   <= SMRAM_RESET[SMRAM_OPEN_BIT];
      smram_smm_en <= SMRAM_RESET[SMRAM_SMM_BIT];
    end else if (cfg_we && cfg_off == SMRAM_OFF) begin
      smram_open   <= cfg_wdata[SMRAM_OPEN_BIT];
      smram_smm_en <= cfg_wdata[SMRAM_SMM_BIT];
    end
  end

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      assert_smram_reset_R1: assert (!smram_open && !smram_smm_en && top_attr == 2'b00)
        else $error("control bits not at reset value after reset");
    end
  end

  assert_smram_write_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_off == SMRAM_OFF) |=>
      (smram_open == $past(cfg_wdata[SMRAM_OPEN_BIT]) &&
       smram_smm_en == $past(cfg_wdata[SMRAM_SMM_BIT])));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we) |=> ($stable(top_attr) && $stable(seg_attr_flat) &&
                   $stable(smram_open) && $stable(smram_smm_en)));

endmodule

// File: rtl/lrd_region_map.sv
module lrd_region_map
  import lrd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_IDX_W = 4
) (
  input  logic [ADDR_W-1:0]    acc_addr,
  output region_e              region,
  output logic [SEG_IDX_W-1:0] seg_idx
);

  localparam logic [19:0] LEGACY_LO = 20'hA0000;

  logic        hi_zero;
  logic [19:0] low;

  assign low = acc_addr[19:0];

  if (ADDR_W > 20) begin : g_hi
    assign hi_zero = (acc_addr[ADDR_W-1:20] == '0);
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  always_comb begin
    if (!hi_zero || low < LEGACY_LO)
      region = RG_OUTSIDE;
    else if (low[19:17] == 3'b101)
      region = RG_VIDEO;
    else if (low[19:16] == 4'hF)
      region = RG_TOP;
    else
      region = RG_SEG;
  end

  // C0000 has bits 17:14 clear, so these bits index the segment directly
  assign seg_idx = low[SEG_SHIFT +: SEG_IDX_W];

endmodule

// File: rtl/lrd_attr_select.sv
module lrd_attr_select
  import lrd_pkg::*;
#(
  parameter int NUM_SEG   = 12,
  parameter int SEG_IDX_W = 4
) (
  input  region_e              region,
  input  logic [SEG_IDX_W-1:0] seg_idx,
  input  logic [1:0]           top_attr,
  input  logic [NUM_SEG*2-1:0] seg_attr_flat,
  output attr_e                attr
);

  localparam int SLOTS = 1 << SEG_IDX_W;

  logic [1:0] slot_attr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_SEG) begin : g_used
      assign slot_attr[s] = seg_attr_flat[s*2 +: 2];
    end else begin : g_pad
      assign slot_attr[s] = 2'b00;
    end
  end

  always_comb begin
    unique case (region)
      RG_TOP:  attr = attr_e'(top_attr);
      RG_SEG:  attr = attr_e'(slot_attr[seg_idx]);
      default: attr = AT_FWD_A;
    endcase
  end

endmodule

// File: rtl/lrd_route_reg.sv
module lrd_route_reg
  import lrd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  region_e region,
  input  attr_e   attr,
  input  logic    smram_open,
  input  logic    smram_smm_en,
  input  logic    smm_active,
  input  logic    acc_write,
  output logic    dram_sel,
  output logic    wr_block
);

  logic dram_nxt;
  logic block_nxt;

  always_comb begin
    dram_nxt  = 1'b0;
    block_nxt = 1'b0;
    unique case (region)
      RG_OUTSIDE: dram_nxt = 1'b1;
      RG_VIDEO:   dram_nxt = smram_open || (smm_active && smram_smm_en);
      default: begin
        unique case (attr)
          AT_RDWR:   dram_nxt = 1'b1;
          AT_RDONLY: begin
            dram_nxt  = 1'b1;
            block_nxt = acc_write;
          end
          default:   dram_nxt = 1'b0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_sel <= 1'b0;
      wr_block <= 1'b0;
    end else begin
      dram_sel <= dram_nxt;
      wr_block <= block_nxt;
    end
  end

  assert_outside_dram_R10: assert property (@(posedge clk) disable iff (rst)
    (region == RG_OUTSIDE) |=> (dram_sel && !wr_block));

  assert_read_not_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (!acc_write) |=> !wr_block);

  assert_video_closed_R8: assert property (@(posedge clk) disable iff (rst)
    (region == RG_VIDEO && !smram_open && !smram_smm_en) |=> (!dram_sel && !wr_block));

  assert_block_implies_dram_R6: assert property (@(posedge clk) disable iff (rst)
    wr_block |-> dram_sel);

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
  import lrd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_wdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              dram_sel,
  output logic              wr_block
);

  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  logic [1:0]           top_attr;
  logic [NUM_SEG*2-1:0] seg_attr_flat;
  logic                 smram_open;
  logic                 smram_smm_en;
  region_e              region;
  logic [SEG_IDX_W-1:0] seg_idx;
  attr_e                attr;

  lrd_cfg_regs #(.NUM_SEG(NUM_SEG), .OFF_W(8), .DATA_W(8)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_off      (cfg_off),
    .cfg_wdata    (cfg_wdata),
    .top_attr     (top_attr),
    .seg_attr_flat(seg_attr_flat),
    .smram_open   (smram_open),
    .smram_smm_en (smram_smm_en)
  );

  lrd_region_map #(.ADDR_W(ADDR_W), .SEG_IDX_W(SEG_IDX_W)) u_map (
    .acc_addr(acc_addr),
    .region  (region),
    .seg_idx (seg_idx)
  );

  lrd_attr_select #(.NUM_SEG(NUM_SEG), .SEG_IDX_W(SEG_IDX_W)) u_sel (
    .region       (region),
    .seg_idx      (seg_idx),
    .top_attr     (top_attr),
    .seg_attr_flat(seg_attr_flat),
    .attr         (attr)
  );

  lrd_route_reg u_route (
    .clk         (clk),
    .rst         (rst),
    .region      (region),
    .attr        (attr),
    .smram_open  (smram_open),
    .smram_smm_en(smram_smm_en),
    .smm_active  (smm_active),
    .acc_write   (acc_write),
    .dram_sel    (dram_sel),
    .wr_block    (wr_block)
  );

  assert_smm_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (region == RG_VIDEO && !smram_smm_en && !smram_open) |=> !dram_sel);

endmodule

// File: tb/sim_legacy_region_decoder.sv
module sim_legacy_region_decoder;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_off = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          smm_active = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          dram_sel;
  logic          wr_block;

  always #4 clk = ~clk;

  legacy_region_decoder #(.ADDR_W(AW), .NUM_SEG(12)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_addr(acc_addr),
    .acc_write(acc_write), .dram_sel(dram_sel), .wr_block(wr_block)
  );

  int    checks = 0;
  int    failures = 0;
  byte   mdl [256];
  bit    exp_d, exp_b, exp_valid = 0;
  string exp_tag;
  string phase = "R1 reset";

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl['h72] = 8'h02;
  endfunction

  function automatic int attr_of(longint unsigned a);
    int k;
    if (a >= 'hF0000) return (mdl['h59] >> 4) & 3;
    k = int'((a - 'hC0000) / 'h4000);
    return (mdl['h5A + k / 2] >> ((k % 2) * 4)) & 3;
  endfunction

  task automatic calc(input longint unsigned a, input bit w, input bit s,
                      output bit d, output bit b, output string tag);
    int at;
    b = 0;
    if (a < 'hA0000 || a > 'hFFFFF) begin
      d = 1; tag = "R10 outside";
    end else if (a < 'hC0000) begin
      d = mdl['h72][6] || (s && mdl['h72][3]); tag = "R8 window";
    end else begin
      at = attr_of(a);
      tag = (a >= 'hF0000) ? "R3 top" : "R4 segment";
      case (at)
        3: begin d = 1; tag = {tag, " R5 rw"}; end
        1: begin d = 1; b = w; tag = {tag, " R6 ro"}; end
        default: begin d = 0; tag = {tag, " R7 fwd"}; end
      endcase
    end
  endtask

  task automatic compare();
    if (exp_valid) begin
      checks++;
      if (dram_sel !== exp_d || wr_block !== exp_b) begin
        failures++;
        $display("FAIL %s [%s]: dram_sel=%b wr_block=%b expected %b %b",
                 phase, exp_tag, dram_sel, wr_block, exp_d, exp_b);
      end
    end
  endtask

  task automatic step(input bit r, input longint unsigned a, input bit w, input bit s,
                      input bit we = 0, input byte off = 0, input byte dat = 0);
    bit d, b;
    string t;
    @(negedge clk);
    compare();
    rst = r; acc_addr = AW'(a); acc_write = w; smm_active = s;
    cfg_we = we; cfg_off = off; cfg_wdata = dat;
    if (r) begin
      d = 0; b = 0; t = "R1 in reset"; model_reset();
    end else begin
      calc(a, w, s, d, b, t);
      if (we) mdl[off] = dat;
    end
    exp_d = d; exp_b = b; exp_tag = t; exp_valid = 1;
  endtask

  task automatic cfg(input byte off, input byte dat);
    step(0, 'h0, 0, 0, 1, off, dat);
  endtask

  task automatic sweep(input bit s);
    for (int k = 0; k < 12; k++) begin
      step(0, 'hC0000 + k * 'h4000, 0, s);
      step(0, 'hC0000 + k * 'h4000 + 'h3FFF, 1, s);
    end
    step(0, 'hF0000, 1, s);
    step(0, 'hFFFFF, 0, s);
    step(0, 'hA0000, 1, s);
    step(0, 'hBFFFF, 0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2: run did not end, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    // R1: reset cycles, then all legacy accesses forwarded
    for (int i = 0; i < 3; i++) step(1, 'hF0000, 1, 1, 1, 8'h59, 8'hFF);
    phase = "R1 post-reset";
    sweep(0);
    sweep(1);

    // R3 R4 R5 R6 R7: program mixed attributes
    phase = "R4 program";
    cfg(8'h59, 8'h30); cfg(8'h5A, 8'h13); cfg(8'h5B, 8'h20); cfg(8'h5C, 8'h31);
    cfg(8'h5D, 8'h13); cfg(8'h5E, 8'h02); cfg(8'h5F, 8'h33);
    phase = "R2 attr sweep";
    sweep(0);
    phase = "R3 top ro";
    cfg(8'h59, 8'h10);
    step(0, 'hF8000, 1, 0);
    step(0, 'hF8000, 0, 0);

    // R11: ignored offsets and unused bits, same-cycle write
    phase = "R11 ignored";
    cfg(8'h58, 8'hFF); cfg(8'h60, 8'hFF); cfg(8'h71, 8'hFF); cfg(8'h73, 8'hFF);
    cfg(8'h59, 8'hCF);
    sweep(0);
    phase = "R11 same cycle";
    step(0, 'hC4000, 1, 0, 1, 8'h5A, 8'h10);
    step(0, 'hC4000, 1, 0);
    step(0, 'hC4000, 0, 0, 1, 8'h5A, 8'h30);
    step(0, 'hC4000, 1, 0);

    // R9: smm toggles with window bits clear
    phase = "R9 smm ignored";
    for (int i = 0; i < 6; i++) begin
      step(0, 'hA8000, i % 2, i % 2);
      step(0, 'hD0000, 1, (i + 1) % 2);
      step(0, 'h50000, 0, i % 2);
    end
    // R8: window control
    phase = "R8 smm gated";
    cfg(8'h72, 8'h08);
    step(0, 'hB0000, 0, 0);
    step(0, 'hB0000, 1, 1);
    step(0, 'hBFFFF, 0, 0);
    phase = "R8 open";
    cfg(8'h72, 8'h40);
    step(0, 'hA0000, 1, 0);
    step(0, 'hA0000, 0, 1);
    cfg(8'h72, 8'hB7);
    step(0, 'hA0000, 0, 1);

    // R10: outside addresses
    phase = "R10 outside";
    cfg(8'h59, 8'h00);
    step(0, 'h9FFFF, 1, 0);
    step(0, 'h100000, 1, 1);
    step(0, 'h0, 0, 0);
    step(0, 'hFFFFFFFF, 1, 0);
    step(0, 'h100F0000, 1, 0);

    // R2 R11: random mix
    phase = "R2 R11 random";
    for (int i = 0; i < 3000; i++) begin
      byte offs [10] = '{8'h58, 8'h59, 8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F, 8'h72, 8'h73};
      longint unsigned a;
      a = (i % 17 == 0) ? longint'($urandom) : longint'('h9C000 + ($urandom % 'h68000));
      step(0, a, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
           offs[$urandom % 10], byte'($urandom));
    end
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule